// File: doc/BRIEF.md
# Three-Channel Timer/Counter Block

This block holds three identical 16-bit counter channels that share one register write/read port. Each channel counts one of eight clock sources. Five of them are internal divided-clock enables that arrive as one-cycle pulses from a prescaler outside the block. The other three are external clock lines, on which rising edges are counted. Each channel has an output line (`tioa`) and an input line (`tiob`).

A channel runs in one of two modes. In capture mode, edges on its input line latch the counter value into two holding registers, one after the other. In waveform mode, three compare registers set and clear the output line and restart the count, which gives a PWM signal. Each channel raises its own interrupt line from its sticky status flags, and reading the status clears it.

A block-level command restarts every enabled channel in the same cycle. A block-level routing register can replace each external clock line with the output of the previous channel, so that the channels can be chained into a longer counter or divider.

Each channel is controlled by a three-state machine:
- OFF: stopped, and the counter holds its value.
- ARMED: enabled, but waiting for a trigger; the counter holds.
- RUN: counting.

Its transitions are:
- OFF→ARMED on an enable without a trigger.
- OFF→RUN on an enable together with a trigger.
- ARMED→RUN on a trigger.
- ARMED→OFF and RUN→OFF on a disable.
- RUN→RUN on a trigger, which restarts the count at zero.

Top module: `tcb_top`

## Requirements
- R1: After reset every counter, compare register, mode, mask and status reads 0, and `tioa` and `irq` are 0.
- R2: The mode field clock select (mode bits [2:0]) picks the source. Values 0–4 select `int_tick[0..4]` and values 5–7 select routed external lines XC0–XC2. A running counter advances by one for each selected internal pulse, or for each rising edge of the selected external line.
- R3: Control writes (offset 1) work as follows. Bit 0 enables, bit 1 disables (disable wins) and bit 2 triggers. A trigger on an OFF channel without enable is ignored. An ARMED or OFF channel never counts.
- R4: A block control write (address 24, bit 0 set) moves every ARMED or RUN channel to RUN with its counter at 0, on the same clock edge. OFF channels are not affected.
- R5: Block routing register (address 25) bit n set makes XCn the `tioa` of channel (n+2) mod 3 instead of `ext_clk[n]`. This lets one channel count another channel's output pulses.
- R6: A counter at 0xFFFF that receives a count wraps to 0 and sets status bit 0.
- R7: In waveform mode (mode bit 3 = 1), a count taken while the counter equals RA drives `tioa` high (mode bit 4 = 0) or low (bit 4 = 1), and sets status bit 1. A count at RB drives the opposite level and sets status bit 2. When RA equals RB, RB wins.
- R8: In waveform mode, a count taken while the counter equals RC reloads 0 and sets status bit 3.
- R9: In capture mode, a `tiob` edge (rising if mode bit 4 = 0, falling if 1) copies the counter into RA and sets status bit 1. The next edge copies it into RB and sets status bit 2, then the sequence alternates. A trigger restarts the sequence at RA.
- R10: Reading the status (offset 6) returns the flags and clears them at that clock edge.
- R11: `irq[c]` is high exactly while channel c has a status bit set whose mask bit (offset 7) is also set.

Channel c registers sit at address c*8+offset: mode 0, control 1, counter 2, RA 3, RB 4, RC 5, status 6, mask 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data (same cycle) |
| int_tick | input | 5 | Internal divided-clock enable pulses |
| ext_clk | input | 3 | External clock lines |
| tiob | input | 3 | Per-channel capture inputs |
| tioa | output | 3 | Per-channel waveform outputs |
| irq | output | 3 | Per-channel interrupt requests |

## Verification
In the clock-select sweep, all eight sources pulse at the same time, each a different number of times (source k pulses k+3 times). A counter result therefore names exactly which source was routed, and a wrong selection cannot hide.

The waveform sequence chains channel 0's PWM output into channel 1. This separates correct routing and edge counting from a counter that merely ticks with the shared input. The two polarity settings and the RA=RB case tell the set/clear priority apart.

The capture tests alternate edges so that a missing RA/RB toggle or a wrong edge sense shows up as a wrong captured value. The long overflow run confirms the wrap, the flag, the interrupt and the clear on read.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ARMED = 2'd1,
        CH_RUN   = 2'd2
    } ch_state_t;

    localparam int OFS_MODE = 0;
    localparam int OFS_CTRL = 1;
    localparam int OFS_CV   = 2;
    localparam int OFS_RA   = 3;
    localparam int OFS_RB   = 4;
    localparam int OFS_RC   = 5;
    localparam int OFS_STAT = 6;
    localparam int OFS_MASK = 7;

    localparam int BLK_CTRL = 0;
    localparam int BLK_ROUTE = 1;

    localparam int STAT_W = 4;
    localparam int ST_OVF = 0;
    localparam int ST_A   = 1;
    localparam int ST_B   = 2;
    localparam int ST_C   = 3;
endpackage

// File: rtl/tcb_route.sv
module tcb_route #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ext_clk,
    input  logic [NCH-1:0] tioa,
    input  logic [NCH-1:0] route,
    output logic [NCH-1:0] xc_edge
);
    logic [NCH-1:0] xc;
    logic [NCH-1:0] xc_q;

    for (genvar n = 0; n < NCH; n++) begin : g_xc
        // route bit set: take the previous channel's waveform output
        assign xc[n]      = route[n] ? tioa[(n + NCH - 1) % NCH] : ext_clk[n];
        assign xc_edge[n] = xc[n] & ~xc_q[n];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) xc_q <= '0;
        else        xc_q <= xc;
    end
endmodule

// File: rtl/tcb_chan.sv
module tcb_chan
    import tcb_pkg::*;
#(
    parameter int CW   = 16,
    parameter int NINT = 5,
    parameter int NEXT = 3,
    localparam int NSRC = NINT + NEXT,
    localparam int SELW = $clog2(NSRC),
    localparam int MW   = SELW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NINT-1:0]   int_tick,
    input  logic [NEXT-1:0]   xc_edge,
    input  logic              tiob,
    input  logic [CW-1:0]     wr_data,
    input  logic              wr_mode,
    input  logic              wr_ctrl,
    input  logic              wr_ra,
    input  logic              wr_rb,
    input  logic              wr_rc,
    input  logic              wr_mask,
    input  logic              sync_trig,
    input  logic              stat_clr,
    output logic [CW-1:0]     cv,
    output logic [CW-1:0]     ra,
    output logic [CW-1:0]     rb,
    output logic [CW-1:0]     rc,
    output logic [MW-1:0]     mode,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic              tioa,
    output logic              irq,
    output logic              running
);
    ch_state_t state_q, state_d;

    logic [NSRC-1:0]   srcs;
    logic              tick, en_req, dis_req, trig, restart;
    logic              wave, pol, tiob_q, tiob_edge, cap_b, cap_b_d, tioa_d;
    logic [CW-1:0]     cv_d, ra_d, rb_d;
    logic [STAT_W-1:0] ev;

    assign srcs    = {xc_edge, int_tick};
    assign tick    = srcs[mode[SELW-1:0]];
    assign wave    = mode[SELW];
    assign pol     = mode[SELW+1];
    assign en_req  = wr_ctrl & wr_data[0];
    assign dis_req = wr_ctrl & wr_data[1];
    assign trig    = (wr_ctrl & wr_data[2]) | sync_trig;
    assign restart = trig & ~dis_req & ((state_q != CH_OFF) | en_req);
    assign tiob_edge = pol ? (tiob_q & ~tiob) : (tiob & ~tiob_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF:   if (en_req && !dis_req) state_d = trig ? CH_RUN : CH_ARMED;
            CH_ARMED: if (dis_req) state_d = CH_OFF;
                      else if (trig) state_d = CH_RUN;
            CH_RUN:   if (dis_req) state_d = CH_OFF;
            default:  state_d = CH_OFF;
        endcase
    end

    // outputs and datapath next values
    always_comb begin
        cv_d    = cv;
        tioa_d  = tioa;
        cap_b_d = cap_b;
        ra_d    = wr_ra ? wr_data : ra;
        rb_d    = wr_rb ? wr_data : rb;
        ev      = '0;
        if (restart) begin
            cv_d    = '0;
            cap_b_d = 1'b0;
        end else if (state_q == CH_RUN) begin
            if (tick) begin
                if (wave && cv == rc) begin
                    cv_d = '0;
                    ev[ST_C] = 1'b1;
                end else if (cv == '1) begin
                    cv_d = '0;
                    ev[ST_OVF] = 1'b1;
                end else begin
                    cv_d = cv + CW'(1);
                end
                if (wave && cv == ra) begin
                    tioa_d = ~pol;
                    ev[ST_A] = 1'b1;
                end
                if (wave && cv == rb) begin
                    tioa_d = pol;
                    ev[ST_B] = 1'b1;
                end
            end
            if (!wave && tiob_edge) begin
                if (cap_b) begin
                    rb_d = cv;
                    ev[ST_B] = 1'b1;
                end else begin
                    ra_d = cv;
                    ev[ST_A] = 1'b1;
                end
                cap_b_d = ~cap_b;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cv     <= '0;
            ra     <= '0;
            rb     <= '0;
            rc     <= '0;
            mode   <= '0;
            mask   <= '0;
            status <= '0;
            tioa   <= 1'b0;
            tiob_q <= 1'b0;
            cap_b  <= 1'b0;
        end else begin
            cv     <= cv_d;
            ra     <= ra_d;
            rb     <= rb_d;
            tioa   <= tioa_d;
            tiob_q <= tiob;
            cap_b  <= cap_b_d;
            status <= (status & ~{STAT_W{stat_clr}}) | ev;
            if (wr_rc)   rc   <= wr_data;
            if (wr_mode) mode <= wr_data[MW-1:0];
            if (wr_mask) mask <= wr_data[STAT_W-1:0];
        end
    end

    assign irq     = |(status & mask);
    assign running = (state_q == CH_RUN);
endmodule

// File: rtl/tcb_top.sv
module tcb_top
    import tcb_pkg::*;
#(
    parameter int CW   = 16,
    parameter int NCH  = 3,
    parameter int NINT = 5,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [CW-1:0]   wr_data,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    output logic [CW-1:0]   rd_data,
    input  logic [NINT-1:0] int_tick,
    input  logic [NCH-1:0]  ext_clk,
    input  logic [NCH-1:0]  tiob,
    output logic [NCH-1:0]  tioa,
    output logic [NCH-1:0]  irq
);
    localparam int SW   = AW - 3;
    localparam int SELW = $clog2(NINT + NCH);
    localparam int MW   = SELW + 2;

    logic [SW-1:0]  wsel, rsel;
    logic [2:0]     wofs, rofs;
    logic [NCH-1:0] route_q, xc_edge, ch_run;
    logic           sync_trig;
    logic [NCH*CW-1:0] ch_cv;

    logic [CW-1:0]     cv_a [NCH];
    logic [CW-1:0]     ra_a [NCH];
    logic [CW-1:0]     rb_a [NCH];
    logic [CW-1:0]     rc_a [NCH];
    logic [MW-1:0]     md_a [NCH];
    logic [STAT_W-1:0] st_a [NCH];
    logic [STAT_W-1:0] mk_a [NCH];

    assign wsel = wr_addr[AW-1:3];
    assign wofs = wr_addr[2:0];
    assign rsel = rd_addr[AW-1:3];
    assign rofs = rd_addr[2:0];
    assign sync_trig = wr_en && wsel == SW'(NCH) && wofs == 3'(BLK_CTRL) && wr_data[0];

    always_ff @(posedge clk) begin
        if (!rst_n) route_q <= '0;
        else if (wr_en && wsel == SW'(NCH) && wofs == 3'(BLK_ROUTE))
            route_q <= wr_data[NCH-1:0];
    end

    tcb_route #(.NCH(NCH)) u_route (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .tioa(tioa),
        .route(route_q), .xc_edge(xc_edge)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = wr_en && wsel == SW'(c);
        tcb_chan #(.CW(CW), .NINT(NINT), .NEXT(NCH)) u_chan (
            .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .xc_edge(xc_edge),
            .tiob(tiob[c]), .wr_data(wr_data),
            .wr_mode(hit && wofs == 3'(OFS_MODE)),
            .wr_ctrl(hit && wofs == 3'(OFS_CTRL)),
            .wr_ra(hit && wofs == 3'(OFS_RA)),
            .wr_rb(hit && wofs == 3'(OFS_RB)),
            .wr_rc(hit && wofs == 3'(OFS_RC)),
            .wr_mask(hit && wofs == 3'(OFS_MASK)),
            .sync_trig(sync_trig),
            .stat_clr(rd_en && rsel == SW'(c) && rofs == 3'(OFS_STAT)),
            .cv(cv_a[c]), .ra(ra_a[c]), .rb(rb_a[c]), .rc(rc_a[c]),
            .mode(md_a[c]), .status(st_a[c]), .mask(mk_a[c]),
            .tioa(tioa[c]), .irq(irq[c]), .running(ch_run[c])
        );
        assign ch_cv[c*CW +: CW] = cv_a[c];
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (rsel == SW'(NCH) && rofs == 3'(BLK_ROUTE)) rd_data = CW'(route_q);
            for (int c = 0; c < NCH; c++) begin
                if (rsel == SW'(c)) begin
                    case (rofs)
                        3'(OFS_MODE): rd_data = CW'(md_a[c]);
                        3'(OFS_CV):   rd_data = cv_a[c];
                        3'(OFS_RA):   rd_data = ra_a[c];
                        3'(OFS_RB):   rd_data = rb_a[c];
                        3'(OFS_RC):   rd_data = rc_a[c];
                        3'(OFS_STAT): rd_data = CW'(st_a[c]);
                        3'(OFS_MASK): rd_data = CW'(mk_a[c]);
                        default:      rd_data = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/tcb_chk.sv
module tcb_chk #(
    parameter int CW  = 16,
    parameter int NCH = 3,
    parameter int AW  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic              sync_bit,
    input logic [NCH-1:0]    ch_run,
    input logic [NCH*CW-1:0] ch_cv,
    input logic [NCH-1:0]    tioa,
    input logic [NCH-1:0]    irq
);
    // R1: reset clears counters and outputs
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (ch_cv == '0 && tioa == '0 && irq == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_c
        // R4: block start leaves every running channel at zero
        a_r4_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == AW'(NCH*8) && sync_bit)
            |=> (!ch_run[c] || ch_cv[c*CW +: CW] == '0));

        // R3: a channel not running keeps its counter
        a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_run[c] |=> (ch_run[c] || $stable(ch_cv[c*CW +: CW])));

        // R2: a running counter moves by at most one step (or restarts)
        a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            ch_run[c] |=> (!ch_run[c] || $stable(ch_cv[c*CW +: CW])
                || ch_cv[c*CW +: CW] == '0
                || ch_cv[c*CW +: CW] == $past(ch_cv[c*CW +: CW]) + CW'(1)));
    end
endmodule

bind tcb_top tcb_chk #(.CW(CW), .NCH(NCH), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .sync_bit(wr_data[0]), .ch_run(ch_run), .ch_cv(ch_cv),
    .tioa(tioa), .irq(irq)
);

// File: tb/tcb_top_bench.sv
`timescale 1ns/1ps
module tcb_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [4:0]  int_tick = '0;
    logic [2:0]  ext_clk = '0, tiob = '0;
    logic [2:0]  tioa, irq;
    int total = 0, bad = 0;
    logic [15:0] v;

    always #2.5 clk = ~clk;

    tcb_top u_tcb_top (.*);

    // {clock select, expected count}: source k pulses k+3 times
    localparam logic [7:0] VEC_TAB [8] = '{8'h03, 8'h14, 8'h25, 8'h36,
                                           8'h47, 8'h58, 8'h69, 8'h7A};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 5'(a);
        #1 d = rd_data;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] m, input int n);
        @(negedge clk);
        int_tick = m;
        repeat (n - 1) @(negedge clk);
        @(negedge clk);
        int_tick = '0;
    endtask

    task automatic tiob_set(input int c, input logic b);
        @(negedge clk);
        tiob[c] = b;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_up;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(2, v);  check("R1 cv0", v, 16'h0);
        rd(6, v);  check("R1 status0", v, 16'h0);
        rd(0, v);  check("R1 mode0", v, 16'h0);
        @(negedge clk);
        check("R1 tioa", 16'(tioa), 16'h0);
        check("R1 irq", 16'(irq), 16'h0);

        // R2: clock select sweep over all eight sources
        for (int k = 0; k < 8; k++) begin
            wr(0, int'(VEC_TAB[k][7:4]));
            wr(1, 5);
            for (int i = 0; i < 24; i++) begin
                @(negedge clk);
                for (int j = 0; j < 5; j++)
                    int_tick[j] = (i % 2 == 0) && (i / 2 < j + 3);
                for (int j = 0; j < 3; j++)
                    ext_clk[j] = (i % 2 == 0) && (i / 2 < j + 8);
            end
            @(negedge clk);
            int_tick = '0; ext_clk = '0;
            @(negedge clk);
            wr(1, 2);
            rd(2, v);
            check($sformatf("R2 select %0d", VEC_TAB[k][7:4]), v, 16'(VEC_TAB[k][3:0]));
        end

        // R3: trigger ignored when off, armed does not count
        wr(16+1, 4);
        pulse(5'b00001, 3);
        rd(16+2, v); check("R3 off trigger ignored", v, 16'h0);
        wr(16+1, 1);
        pulse(5'b00001, 3);
        rd(16+2, v); check("R3 armed holds", v, 16'h0);
        wr(16+1, 2);

        // R4: block start
        wr(0, 0);
        wr(1, 1);
        wr(8+1, 1);
        wr(24, 1);
        pulse(5'b00001, 4);
        rd(2, v);    check("R4 ch0 started", v, 16'h4);
        rd(8+2, v);  check("R4 ch1 started", v, 16'h4);
        rd(16+2, v); check("R4 ch2 off untouched", v, 16'h0);
        wr(1, 2); wr(8+1, 2);

        // R7/R8/R5: PWM on ch0, chained into ch1
        wr(0, 8); wr(3, 1); wr(4, 2); wr(5, 3);
        wr(8+0, 6); wr(25, 2);
        rd(6, v);
        wr(8+1, 5); wr(1, 5);
        pulse(5'b00001, 2);
        check("R7 RA sets tioa", 16'(tioa[0]), 16'h1);
        pulse(5'b00001, 1);
        check("R7 RB clears tioa", 16'(tioa[0]), 16'h0);
        pulse(5'b00001, 9);
        repeat (3) @(negedge clk);
        rd(2, v);   check("R8 RC reload", v, 16'h0);
        rd(8+2, v); check("R5 chained count", v, 16'h3);
        rd(6, v);   check("R8 status flags", v, 16'h000E);
        rd(6, v);   check("R10 status cleared", v, 16'h0);
        wr(8+1, 2); wr(25, 0);

        // R7: inverted polarity, then RA==RB priority
        wr(0, 16'h18); wr(1, 5);
        pulse(5'b00001, 2);
        check("R7 inverted RA", 16'(tioa[0]), 16'h0);
        pulse(5'b00001, 1);
        check("R7 inverted RB", 16'(tioa[0]), 16'h1);
        wr(0, 8); wr(4, 1); wr(1, 5);
        pulse(5'b00001, 2);
        check("R7 RB wins tie", 16'(tioa[0]), 16'h0);
        wr(1, 2);

        // R9: capture alternation and edge sense
        wr(16+0, 0); wr(16+1, 5);
        pulse(5'b00001, 5);
        tiob_set(2, 1'b1); tiob_set(2, 1'b0);
        pulse(5'b00001, 3);
        tiob_set(2, 1'b1); tiob_set(2, 1'b0);
        rd(16+3, v); check("R9 RA capture", v, 16'h5);
        rd(16+4, v); check("R9 RB capture", v, 16'h8);
        rd(16+6, v); check("R9 capture flags", v, 16'h6);
        wr(16+0, 16'h10);
        tiob_set(2, 1'b1);
        rd(16+3, v); check("R9 rising ignored in falling mode", v, 16'h5);
        tiob_set(2, 1'b0);
        rd(16+3, v); check("R9 falling captures", v, 16'h8);
        wr(16+1, 2);

        // R6/R11/R10: overflow, interrupt, clear on read
        wr(0, 0); wr(7, 1);
        rd(6, v);
        wr(1, 5);
        @(negedge clk);
        int_tick = 5'b00001;
        repeat (65535) @(negedge clk);
        int_tick = '0;
        rd(2, v); check("R6 reaches max", v, 16'hFFFF);
        check("R11 no irq before wrap", 16'(irq), 16'h0);
        pulse(5'b00001, 1);
        rd(2, v); check("R6 wraps to zero", v, 16'h0);
        @(negedge clk);
        check("R11 irq raised", 16'(irq), 16'h1);
        rd(6, v); check("R6 overflow flag", v, 16'h1);
        @(negedge clk);
        check("R10 irq gone after read", 16'(irq), 16'h0);

        finish_up();
    end
endmodule